// File: doc/BRIEF.md
# Countdown Shut-off Timer with BCD Readout

This block turns an appliance off after a chosen delay. While the appliance is powered, an arm key starts the timer with a half-hour delay. Up and down keys then move the delay in half-hour steps between half an hour and a full day. Every accepted change reloads the countdown from the new delay.

A slow, asynchronous tick, one per simulated minute, counts the remaining time down. The remaining time is kept and shown as four BCD digits in hours:minutes form. When the last minute runs out, the block raises a one-cycle shutdown request and drops back to its idle state. A cancel key or loss of power also returns it to idle, and in that case no request is raised. All key inputs are single-cycle pulses on the system clock.

The controller has two states. ST_IDLE is the reset state, with the digits at zero. ST_COUNT is the armed state. The transitions are:
- ARM: ST_IDLE to ST_COUNT, on the arm key while power is on.
- CANCEL: ST_COUNT to ST_IDLE, on the cancel key.
- EXPIRE: ST_COUNT to ST_IDLE, on a tick at 00:01, which also pulses the shutdown request.
- POWER_DROP: ST_COUNT to ST_IDLE, when the power level is low.

Top module: `shutoff_timer`

## Requirements
- R1: After reset the block is idle: `armed`=0, `shutdown_req`=0 and all four digits read 0.
- R2: In idle with power on, an arm pulse moves the block to counting with the digits at 00:30 after one clock edge. An arm pulse while counting has no effect.
- R3: While counting, an up pulse adds 30 minutes and a down pulse removes 30 minutes, visible one edge later. The countdown restarts from the new value. If up and down arrive together, up wins.
- R4: The delay is clamped to the range 00:30 to 24:00. A press that would leave the range changes nothing, and the running countdown continues.
- R5: The tick is synchronized through two flops and edge-detected. Each rising edge of the tick removes exactly one minute, visible after the third clock edge that follows the rise. A tick in idle has no effect.
- R6: Digits are BCD with ht:hu:mt:mu = hours tens, hours units, minutes tens, minutes units. Minute units borrow from 0 to 9. Minutes borrow from 00 to 59 and decrement the hours, with hour units borrowing from 0 to 9 (for example 24:00→23:59 and 20:00→19:59).
- R7: A cancel pulse while counting returns the block to idle with zero digits, and no shutdown request follows.
- R8: A tick while the digits read 00:01 raises `shutdown_req` for exactly one cycle. In that same cycle `armed` is 0 and the digits read 0.
- R9: While `pwr_on` is low, the block is forced idle by the next edge with zero digits, and every key is ignored.
- R10: Within one cycle, the priority order is power low, then cancel, then arm/up/down, then the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Appliance power level |
| key_arm | input | 1 | Arm pulse |
| key_cancel | input | 1 | Cancel pulse |
| key_up | input | 1 | Add-30-minutes pulse |
| key_down | input | 1 | Remove-30-minutes pulse |
| min_tick | input | 1 | Asynchronous one-per-minute tick |
| armed | output | 1 | High in ST_COUNT |
| shutdown_req | output | 1 | One-cycle power-off request |
| hrs_tens | output | 4 | BCD hours tens |
| hrs_units | output | 4 | BCD hours units |
| min_tens | output | 4 | BCD minutes tens |
| min_units | output | 4 | BCD minutes units |

## Verification
A key pulse driven before an edge shows its result on the digits and on `armed` right after that edge, so the bench checks at the following falling edge. A tick rise takes three edges to act: two synchronizer flops, then the update edge. The bench therefore samples at the second falling edge after the rise, where the old value must still hold, and at the third, where the new value or the shutdown pulse must appear. It samples again one cycle later to show that the pulse has ended. Ticks are held high and then low for four cycles each, so every rise is seen once.

// File: rtl/stm_pkg.sv
package stm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } stm_state_e;

    typedef struct packed {
        logic [3:0] ht;
        logic [3:0] hu;
        logic [3:0] mt;
        logic [3:0] mu;
    } stm_bcd_t;
endpackage

// File: rtl/stm_tick_sync.sv
module stm_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], tick_async};
    end

    assign tick_pulse = sr[STAGES-1] & ~sr[STAGES];

    // R5: one decrement per tick rise, so the pulse never lasts two cycles
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/stm_preset.sv
module stm_preset
    import stm_pkg::*;
#(
    parameter int STEP_MIN  = 30,
    parameter int MAX_STEPS = 48,
    localparam int STEP_W   = $clog2(MAX_STEPS + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     init,
    input  logic     clear,
    input  logic     inc,
    input  logic     dec,
    output logic     changed,
    output stm_bcd_t next_val
);
    logic [STEP_W-1:0] steps_q, steps_n;
    logic [15:0]       tot, hrs, mins;

    always_comb begin
        steps_n = steps_q;
        changed = 1'b0;
        if (init) begin
            steps_n = STEP_W'(1);
            changed = 1'b1;
        end else if (inc) begin
            if (steps_q < STEP_W'(MAX_STEPS)) begin
                steps_n = steps_q + STEP_W'(1);
                changed = 1'b1;
            end
        end else if (dec) begin
            if (steps_q > STEP_W'(1)) begin
                steps_n = steps_q - STEP_W'(1);
                changed = 1'b1;
            end
        end
    end

    always_comb begin
        tot         = 16'(steps_n) * 16'(STEP_MIN);
        hrs         = tot / 16'd60;
        mins        = tot % 16'd60;
        next_val.ht = 4'(hrs / 16'd10);
        next_val.hu = 4'(hrs % 16'd10);
        next_val.mt = 4'(mins / 16'd10);
        next_val.mu = 4'(mins % 16'd10);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) steps_q <= '0;
        else                 steps_q <= steps_n;
    end

    // R4: the step count never leaves its clamp
    assert_preset_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        steps_q <= STEP_W'(MAX_STEPS));
endmodule

// File: rtl/stm_bcd_down.sv
module stm_bcd_down
    import stm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     load,
    input  stm_bcd_t load_val,
    input  logic     dec,
    output stm_bcd_t cnt,
    output logic     at_last
);
    stm_bcd_t nxt;
    logic     b_mt, b_hu, b_ht;

    always_comb begin
        nxt  = cnt;
        b_mt = (cnt.mu == 4'd0);
        b_hu = b_mt && (cnt.mt == 4'd0);
        b_ht = b_hu && (cnt.hu == 4'd0);
        nxt.mu = b_mt ? 4'd9 : cnt.mu - 4'd1;
        if (b_mt) nxt.mt = (cnt.mt == 4'd0) ? 4'd5 : cnt.mt - 4'd1;
        if (b_hu) nxt.hu = (cnt.hu == 4'd0) ? 4'd9 : cnt.hu - 4'd1;
        if (b_ht) nxt.ht = cnt.ht - 4'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (load)     cnt <= load_val;
        else if (dec)      cnt <= nxt;
    end

    assign at_last = (cnt == 16'h0001);

    // R6: every digit stays a legal BCD time digit
    assert_bcd_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt.mu <= 4'd9) && (cnt.mt <= 4'd5) && (cnt.hu <= 4'd9) && (cnt.ht <= 4'd2));
endmodule

// File: rtl/shutoff_timer.sv
module shutoff_timer
    import stm_pkg::*;
#(
    parameter int STEP_MIN    = 30,
    parameter int MAX_STEPS   = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on,
    input  logic       key_arm,
    input  logic       key_cancel,
    input  logic       key_up,
    input  logic       key_down,
    input  logic       min_tick,
    output logic       armed,
    output logic       shutdown_req,
    output logic [3:0] hrs_tens,
    output logic [3:0] hrs_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units
);
    stm_state_e state_q, state_n;
    stm_bcd_t   cnt, preset_val;
    logic       tick_p, changed, at_last;
    logic       do_arm, do_cancel, do_up, do_down, expire_now, to_idle, do_dec;

    stm_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_async(min_tick), .tick_pulse(tick_p)
    );

    // R10 priority: power, cancel, edit keys, tick
    always_comb begin
        do_arm     = (state_q == ST_IDLE)  && pwr_on && key_arm;
        do_cancel  = (state_q == ST_COUNT) && pwr_on && key_cancel;
        do_up      = (state_q == ST_COUNT) && pwr_on && !key_cancel && key_up;
        do_down    = (state_q == ST_COUNT) && pwr_on && !key_cancel && !key_up && key_down;
        expire_now = (state_q == ST_COUNT) && pwr_on && !key_cancel && !changed
                     && tick_p && at_last;
        to_idle    = (state_q == ST_COUNT) && (!pwr_on || do_cancel || expire_now);
        do_dec     = (state_q == ST_COUNT) && !to_idle && !changed && tick_p;
    end

    stm_preset #(.STEP_MIN(STEP_MIN), .MAX_STEPS(MAX_STEPS)) u_preset (
        .clk(clk), .rst_n(rst_n), .init(do_arm), .clear(to_idle),
        .inc(do_up), .dec(do_down), .changed(changed), .next_val(preset_val)
    );

    stm_bcd_down u_count (
        .clk(clk), .rst_n(rst_n), .clr(to_idle), .load(changed && !to_idle),
        .load_val(preset_val), .dec(do_dec), .cnt(cnt), .at_last(at_last)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (do_arm)  state_n = ST_COUNT;  // ARM
            ST_COUNT: if (to_idle) state_n = ST_IDLE;   // CANCEL, EXPIRE, POWER_DROP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shutdown_req <= 1'b0;
        else        shutdown_req <= expire_now;
    end

    assign armed     = (state_q == ST_COUNT);
    assign hrs_tens  = cnt.ht;
    assign hrs_units = cnt.hu;
    assign min_tens  = cnt.mt;
    assign min_units = cnt.mu;

    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);
    assert_fire_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> (!armed && cnt == 16'h0000));
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (cnt == 16'h0000));
    assert_power_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !armed);
    assert_arm_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && key_arm && pwr_on) |=> (armed && cnt == 16'h0030));
endmodule

// File: tb/shutoff_timer_tb_top.sv
module shutoff_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 1'b1;
    logic       key_arm = 1'b0, key_cancel = 1'b0, key_up = 1'b0, key_down = 1'b0;
    logic       min_tick = 1'b0;
    logic       armed, shutdown_req;
    logic [3:0] hrs_tens, hrs_units, min_tens, min_units;

    int errors = 0;
    int checks = 0;
    int sd_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int OP_ARM = 0, OP_UP = 1, OP_DOWN = 2, OP_CANCEL = 3,
                   OP_TICK = 4, OP_PWROFF = 5, OP_PWRON = 6;
    localparam int NVEC = 20;
    // {op, expected digits ht:hu:mt:mu, expected armed}
    localparam logic [20:0] VEC [NVEC] = '{
        {4'd0, 16'h0030, 1'b1},  // R2 arm
        {4'd1, 16'h0100, 1'b1},  // R3 up
        {4'd1, 16'h0130, 1'b1},  // R3 up
        {4'd2, 16'h0100, 1'b1},  // R3 down
        {4'd4, 16'h0059, 1'b1},  // R6 minute borrow
        {4'd4, 16'h0058, 1'b1},  // R5
        {4'd1, 16'h0130, 1'b1},  // R3 restart
        {4'd2, 16'h0100, 1'b1},  // R3
        {4'd2, 16'h0030, 1'b1},  // R3
        {4'd2, 16'h0030, 1'b1},  // R4 min clamp
        {4'd4, 16'h0029, 1'b1},  // R5
        {4'd2, 16'h0029, 1'b1},  // R4 no restart
        {4'd3, 16'h0000, 1'b0},  // R7 cancel
        {4'd1, 16'h0000, 1'b0},  // R3 up ignored in idle
        {4'd0, 16'h0030, 1'b1},  // R2
        {4'd5, 16'h0000, 1'b0},  // R9 power drop
        {4'd0, 16'h0000, 1'b0},  // R9 key ignored
        {4'd6, 16'h0000, 1'b0},  // R9
        {4'd0, 16'h0030, 1'b1},  // R2
        {4'd3, 16'h0000, 1'b0}   // R7
    };

    shutoff_timer dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .key_arm(key_arm),
        .key_cancel(key_cancel), .key_up(key_up), .key_down(key_down),
        .min_tick(min_tick), .armed(armed), .shutdown_req(shutdown_req),
        .hrs_tens(hrs_tens), .hrs_units(hrs_units), .min_tens(min_tens),
        .min_units(min_units)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (shutdown_req) sd_cnt <= sd_cnt + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [15:0] digs();
        return {hrs_tens, hrs_units, min_tens, min_units};
    endfunction

    task automatic chk(input string req, input logic [15:0] ed, input logic ea);
        checks++;
        if (digs() !== ed || armed !== ea) begin
            errors++;
            $display("FAIL %s: got %h armed=%b expected %h armed=%b", req, digs(), armed, ed, ea);
        end
    endtask

    task automatic chk_bit(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic do_op(input int op);
        @(negedge clk);
        case (op)
            OP_ARM:    key_arm = 1'b1;
            OP_UP:     key_up = 1'b1;
            OP_DOWN:   key_down = 1'b1;
            OP_CANCEL: key_cancel = 1'b1;
            OP_PWROFF: pwr_on = 1'b0;
            OP_PWRON:  pwr_on = 1'b1;
            default: ;
        endcase
        if (op == OP_TICK) begin
            min_tick = 1'b1;
            repeat (4) @(negedge clk);
            min_tick = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            @(negedge clk);
            key_arm = 1'b0; key_up = 1'b0; key_down = 1'b0; key_cancel = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 16'h0000, 1'b0);
        chk_bit("R1 reset shutdown", shutdown_req, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            do_op(int'(VEC[i][20:17]));
            chk($sformatf("vector %0d", i), VEC[i][16:1], VEC[i][0]);
        end

        // R4 upper clamp and R6 hour borrow
        do_op(OP_ARM);
        for (int i = 0; i < 47; i++) do_op(OP_UP);
        chk("R4 reach max", 16'h2400, 1'b1);
        do_op(OP_UP);
        chk("R4 max clamp", 16'h2400, 1'b1);
        do_op(OP_TICK);
        chk("R6 24:00 borrow", 16'h2359, 1'b1);
        do_op(OP_UP);
        chk("R4 no restart at max", 16'h2359, 1'b1);
        do_op(OP_ARM);
        chk("R2 arm ignored while counting", 16'h2359, 1'b1);
        do_op(OP_DOWN);
        chk("R3 down reloads", 16'h2330, 1'b1);

        // R6 hour units borrow 20:00 -> 19:59
        do_op(OP_CANCEL);
        do_op(OP_ARM);
        for (int i = 0; i < 39; i++) do_op(OP_UP);
        chk("R3 reach 20:00", 16'h2000, 1'b1);
        do_op(OP_TICK);
        chk("R6 20:00 borrow", 16'h1959, 1'b1);

        // R5 tick in idle ignored
        do_op(OP_CANCEL);
        do_op(OP_TICK);
        chk("R5 idle tick", 16'h0000, 1'b0);

        // R5 latency
        do_op(OP_ARM);
        @(negedge clk);
        min_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 not yet", 16'h0030, 1'b1);
        @(negedge clk);
        chk("R5 third edge", 16'h0029, 1'b1);
        @(negedge clk);
        min_tick = 1'b0;
        repeat (4) @(negedge clk);

        // R8 expiry
        for (int i = 0; i < 28; i++) do_op(OP_TICK);
        chk("R8 at 00:01", 16'h0001, 1'b1);
        @(negedge clk);
        min_tick = 1'b1;
        @(negedge clk);
        chk_bit("R8 early", shutdown_req, 1'b0);
        @(negedge clk);
        chk_bit("R8 early2", shutdown_req, 1'b0);
        @(negedge clk);
        chk_bit("R8 fire", shutdown_req, 1'b1);
        chk("R8 idle at fire", 16'h0000, 1'b0);
        @(negedge clk);
        chk_bit("R8 single cycle", shutdown_req, 1'b0);
        min_tick = 1'b0;
        repeat (4) @(negedge clk);
        chk_bit("R8 pulse count", (sd_cnt == 1), 1'b1);

        // R7 cancel suppresses shutdown
        do_op(OP_ARM);
        for (int i = 0; i < 29; i++) do_op(OP_TICK);
        chk("R7 at 00:01", 16'h0001, 1'b1);
        do_op(OP_CANCEL);
        for (int i = 0; i < 3; i++) do_op(OP_TICK);
        chk("R7 after cancel", 16'h0000, 1'b0);
        chk_bit("R7 no shutdown", (sd_cnt == 1), 1'b1);

        // R10 cancel wins over up
        do_op(OP_ARM);
        @(negedge clk);
        key_cancel = 1'b1; key_up = 1'b1;
        @(negedge clk);
        key_cancel = 1'b0; key_up = 1'b0;
        chk("R10 cancel over up", 16'h0000, 1'b0);
        // R10 power over up
        do_op(OP_ARM);
        @(negedge clk);
        pwr_on = 1'b0; key_up = 1'b1;
        @(negedge clk);
        key_up = 1'b0;
        chk("R10 power over up", 16'h0000, 1'b0);
        pwr_on = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule